// File: doc/BRIEF.md
# Dual-Mode External Interrupt Detector

This block turns a set of active-low external interrupt pins (two by default) into prioritised requests for a small microcontroller core. Each pin passes through a synchronizer. It is then watched in one of two ways, chosen per channel at run time. In level sensing, the channel's request flag mirrors a low pin on every cycle. In falling-edge sensing, a high-to-low change latches a flag that stays set until the CPU takes the vector or software clears it.

Software controls the block through a single write port. A byte write reaches the control register or the enable register. A single-bit write reaches one field of either register. A channel whose flag and enable are both set raises a registered pending bit. The block presents the fixed service address of the lowest-numbered pending channel to the CPU. The CPU answers with a one-hot acknowledge.

Top module: `xint_detect`

## Requirements
- R1: After reset, every request flag, pending bit and `irq_req` is 0, `irq_vec` is 0, all channels are in level mode and all enables are 0.
- R2: In level mode (type bit 0) a channel's flag is set while its synchronized pin is low and clears once the pin is high again.
- R3: In edge mode (type bit 1) a falling edge on the synchronized pin sets the flag, which stays set after the pin returns high.
- R4: In edge mode, a pin held low, a rising edge, or a pin already low during reset does not set the flag.
- R5: An acknowledge clears the flag of an edge-mode channel; in level mode it has no effect while the pin stays low.
- R6: A byte write to control address 0x88 loads channel i's type bit from data bit 2i and its flag from data bit 2i+1.
- R7: A bit write (`wr_bit`=1) to address 0x88+2i sets channel i's type, to 0x89+2i its flag, and to 0xA8+i its enable, from `wr_data[0]`; other fields keep their value.
- R8: `irq_pend[i]` is set one cycle after flag i and enable i are both 1. A byte write to enable address 0xA8 loads enable i from data bit i, and a flag whose enable is 0 does not reach `irq_pend`.
- R9: `irq_vec` is 0x0003 when channel 0 is pending. Otherwise it is 0x0013 when channel 1 is pending. With nothing pending it is 0 and `irq_req` is low.
- R10: A flag set by software raises a request and is cleared by an acknowledge exactly as a pin-generated one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_int_n | input | NUM_CH | Active-low interrupt pins, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_bit | input | 1 | 1: single-bit write, 0: byte write |
| wr_addr | input | AW | Byte or bit address |
| wr_data | input | DW | Byte data; bit 0 carries the value of a bit write |
| irq_ack | input | NUM_CH | One-hot acknowledge from the CPU |
| req_flag | output | NUM_CH | Request flags as software sees them |
| irq_pend | output | NUM_CH | Registered enabled-and-flagged requests |
| irq_req | output | 1 | Any request pending |
| irq_vec | output | VW | Service address of the winning channel, 0 if none |

## Verification
Each channel is driven with held-low pins, low pulses followed by release, and pins already low across reset. These patterns separate level tracking from latched edges and from false edges. Acknowledges arrive with the pin still low in level mode and after a latched edge in edge mode, which shows which mode honours the clear. Byte and bit writes, each aimed at one field, show that the neighbouring fields stay unchanged. Both channels pending at once, then acknowledged one at a time, walk the vector through 0x0003, 0x0013 and 0.

// File: rtl/xint_pkg.sv
package xint_pkg;
   localparam int unsigned MAX_CH = 4;

   typedef enum logic {
      TRIG_LEVEL = 1'b0,
      TRIG_FALL  = 1'b1
   } trig_e;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
   parameter int unsigned W      = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] st;

   // during reset every stage follows the pin so history starts at its level
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) st[s] <= d;
      end else begin
         st[0] <= d;
         for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/xint_regs.sv
module xint_regs #(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned AW     = 8,
   parameter int unsigned DW     = 8,
   parameter logic [AW-1:0] CTRL_ADDR = 8'h88,
   parameter logic [AW-1:0] ENA_ADDR  = 8'hA8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_bit,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DW-1:0]     wr_data,
   output logic [NUM_CH-1:0] trig_mode,
   output logic [NUM_CH-1:0] ena_bits,
   output logic [NUM_CH-1:0] flag_we,
   output logic [NUM_CH-1:0] flag_wd
);
   localparam int unsigned TYPE_POS_STEP = 2;

   logic byte_ctrl, byte_ena;
   assign byte_ctrl = wr_en && !wr_bit && (wr_addr == CTRL_ADDR);
   assign byte_ena  = wr_en && !wr_bit && (wr_addr == ENA_ADDR);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam logic [AW-1:0] TYPE_BA = CTRL_ADDR + AW'(TYPE_POS_STEP*i);
      localparam logic [AW-1:0] FLAG_BA = CTRL_ADDR + AW'(TYPE_POS_STEP*i + 1);
      localparam logic [AW-1:0] ENA_BA  = ENA_ADDR + AW'(i);

      logic bit_type, bit_flag, bit_ena;
      assign bit_type = wr_en && wr_bit && (wr_addr == TYPE_BA);
      assign bit_flag = wr_en && wr_bit && (wr_addr == FLAG_BA);
      assign bit_ena  = wr_en && wr_bit && (wr_addr == ENA_BA);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            trig_mode[i] <= xint_pkg::TRIG_LEVEL;
            ena_bits[i]  <= 1'b0;
         end else begin
            if (byte_ctrl)     trig_mode[i] <= wr_data[TYPE_POS_STEP*i];
            else if (bit_type) trig_mode[i] <= wr_data[0];
            if (byte_ena)      ena_bits[i]  <= wr_data[i];
            else if (bit_ena)  ena_bits[i]  <= wr_data[0];
         end
      end

      assign flag_we[i] = byte_ctrl | bit_flag;
      assign flag_wd[i] = byte_ctrl ? wr_data[TYPE_POS_STEP*i + 1] : wr_data[0];
   end
endmodule

// File: rtl/xint_chan.sv
module xint_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic trig_mode,
   input  logic ack,
   input  logic flag_we,
   input  logic flag_wd,
   output logic flag
);
   logic prev;
   logic fall;

   assign fall = prev & ~pin_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev <= pin_s;
         flag <= 1'b0;
      end else begin
         prev <= pin_s;
         if (flag_we)
            flag <= flag_wd;
         else if (trig_mode == xint_pkg::TRIG_LEVEL)
            flag <= ~pin_s;
         else if (fall)
            flag <= 1'b1;
         else if (ack)
            flag <= 1'b0;
      end
   end
endmodule

// File: rtl/xint_arb.sv
module xint_arb #(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned VW     = 16,
   parameter logic [VW-1:0] VEC_BASE = 16'h0003,
   parameter logic [VW-1:0] VEC_STEP = 16'h0010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] flag,
   input  logic [NUM_CH-1:0] ena,
   output logic [NUM_CH-1:0] pend,
   output logic              req,
   output logic [VW-1:0]     vec
);
   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= flag & ena;
   end

   assign req = |pend;

   // scan from the highest index down so the lowest pending channel wins
   always_comb begin
      vec = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (pend[i]) vec = VEC_BASE + VW'(i) * VEC_STEP;
      end
   end
endmodule

// File: rtl/xint_detect.sv
module xint_detect #(
   parameter int unsigned NUM_CH      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned AW          = 8,
   parameter int unsigned DW          = 8,
   parameter int unsigned VW          = 16,
   parameter logic [AW-1:0] CTRL_ADDR = 8'h88,
   parameter logic [AW-1:0] ENA_ADDR  = 8'hA8,
   parameter logic [VW-1:0] VEC_BASE  = 16'h0003,
   parameter logic [VW-1:0] VEC_STEP  = 16'h0010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ext_int_n,
   input  logic              wr_en,
   input  logic              wr_bit,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [NUM_CH-1:0] irq_ack,
   output logic [NUM_CH-1:0] req_flag,
   output logic [NUM_CH-1:0] irq_pend,
   output logic              irq_req,
   output logic [VW-1:0]     irq_vec
);
   if (NUM_CH < 1 || NUM_CH > xint_pkg::MAX_CH) begin : g_bad_ch
      $error("xint_detect: NUM_CH out of range");
   end
   if (DW < 2 * NUM_CH) begin : g_bad_dw
      $error("xint_detect: DW too narrow for control fields");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xint_detect: at least two synchronizer stages required");
   end

   logic [NUM_CH-1:0] pin_sync;
   logic [NUM_CH-1:0] trig_mode;
   logic [NUM_CH-1:0] ena_bits;
   logic [NUM_CH-1:0] flag_we;
   logic [NUM_CH-1:0] flag_wd;

   xint_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ext_int_n), .q(pin_sync)
   );

   xint_regs #(
      .NUM_CH(NUM_CH), .AW(AW), .DW(DW),
      .CTRL_ADDR(CTRL_ADDR), .ENA_ADDR(ENA_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .trig_mode(trig_mode), .ena_bits(ena_bits),
      .flag_we(flag_we), .flag_wd(flag_wd)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      xint_chan u_chan (
         .clk(clk), .rst_n(rst_n), .pin_s(pin_sync[i]),
         .trig_mode(trig_mode[i]), .ack(irq_ack[i]),
         .flag_we(flag_we[i]), .flag_wd(flag_wd[i]),
         .flag(req_flag[i])
      );
   end

   xint_arb #(
      .NUM_CH(NUM_CH), .VW(VW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
   ) u_arb (
      .clk(clk), .rst_n(rst_n), .flag(req_flag), .ena(ena_bits),
      .pend(irq_pend), .req(irq_req), .vec(irq_vec)
   );
endmodule

// File: rtl/xint_detect_chk.sv
module xint_detect_chk #(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned VW     = 16,
   parameter logic [VW-1:0] VEC_BASE = 16'h0003
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] pin_s,
   input logic [NUM_CH-1:0] trig,
   input logic [NUM_CH-1:0] ena,
   input logic [NUM_CH-1:0] flag_we,
   input logic [NUM_CH-1:0] flag,
   input logic [NUM_CH-1:0] ack,
   input logic [NUM_CH-1:0] pend,
   input logic              req,
   input logic [VW-1:0]     vec
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_p
      // R2
      level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!trig[i] && !flag_we[i] && !pin_s[i]) |=> flag[i]);
      // R3
      edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (trig[i] && flag[i] && !ack[i] && !flag_we[i]) |=> flag[i]);
      // R4
      edge_no_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (trig[i] && !flag[i] && !flag_we[i] && !($past(pin_s[i]) && !pin_s[i]))
         |=> !flag[i]);
      // R5
      edge_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (trig[i] && flag[i] && ack[i] && !flag_we[i] && !($past(pin_s[i]) && !pin_s[i]))
         |=> !flag[i]);
      // R8
      pend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flag[i] && ena[i]) |=> pend[i]);
   end

   // R9
   vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req |-> (vec == '0 && pend == '0));
   // R9
   vec_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend[0] |-> vec == VEC_BASE);
endmodule

bind xint_detect xint_detect_chk #(
   .NUM_CH(NUM_CH), .VW(VW), .VEC_BASE(VEC_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_s(pin_sync), .trig(trig_mode),
   .ena(ena_bits), .flag_we(flag_we), .flag(req_flag), .ack(irq_ack),
   .pend(irq_pend), .req(irq_req), .vec(irq_vec)
);

// File: tb/xint_detect_bench.sv
module xint_detect_bench;
   localparam logic [7:0] CTRL = 8'h88;
   localparam logic [7:0] ENA  = 8'hA8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ext_int_n = 2'b11;
   logic        wr_en = 1'b0;
   logic        wr_bit = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [1:0]  irq_ack = '0;
   logic [1:0]  req_flag, irq_pend;
   logic        irq_req;
   logic [15:0] irq_vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   xint_detect u_xint_detect (
      .clk(clk), .rst_n(rst_n), .ext_int_n(ext_int_n),
      .wr_en(wr_en), .wr_bit(wr_bit), .wr_addr(wr_addr), .wr_data(wr_data),
      .irq_ack(irq_ack), .req_flag(req_flag), .irq_pend(irq_pend),
      .irq_req(irq_req), .irq_vec(irq_vec)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_bit = 1'b0; wr_addr = a; wr_data = d;
      step(1);
      wr_en = 1'b0;
   endtask

   task automatic wr_one(input logic [7:0] a, input logic v);
      wr_en = 1'b1; wr_bit = 1'b1; wr_addr = a; wr_data = {7'd0, v};
      step(1);
      wr_en = 1'b0; wr_bit = 1'b0;
   endtask

   task automatic ack(input logic [1:0] m);
      irq_ack = m;
      step(1);
      irq_ack = '0;
   endtask

   task automatic t_reset();
      ext_int_n = 2'b11;
      do_reset();
      chk("R1 flags", req_flag, 2'b00);
      chk("R1 pend", irq_pend, 2'b00);
      chk("R1 req", irq_req, 1'b0);
      chk("R1 vec", irq_vec, 16'h0);
   endtask

   task automatic t_level();
      ext_int_n = 2'b11;
      do_reset();
      ext_int_n = 2'b10; step(5);
      chk("R2 level low sets", req_flag, 2'b01);
      ext_int_n = 2'b11; step(5);
      chk("R2 level high clears", req_flag, 2'b00);
   endtask

   task automatic t_edge();
      ext_int_n = 2'b11;
      do_reset();
      wr_byte(CTRL, 8'h05);
      ext_int_n = 2'b01; step(5);
      chk("R3 fall sets", req_flag, 2'b10);
      ext_int_n = 2'b11; step(5);
      chk("R3 sticky", req_flag, 2'b10);
   endtask

   task automatic t_noedge();
      ext_int_n = 2'b10;
      do_reset();
      wr_byte(CTRL, 8'h01);
      step(5);
      chk("R4 low at reset", req_flag[0], 1'b0);
      ext_int_n = 2'b11; step(5);
      chk("R4 rising", req_flag[0], 1'b0);
      ext_int_n = 2'b10; step(5);
      chk("R4 later fall", req_flag[0], 1'b1);
   endtask

   task automatic t_ack();
      ext_int_n = 2'b11;
      do_reset();
      wr_byte(CTRL, 8'h01);
      ext_int_n = 2'b10; step(5);
      chk("R5 edge set", req_flag[0], 1'b1);
      ack(2'b01); step(3);
      chk("R5 edge ack clears", req_flag[0], 1'b0);
      wr_byte(CTRL, 8'h00); step(3);
      ack(2'b01); step(3);
      chk("R5 level ack ignored", req_flag[0], 1'b1);
      ext_int_n = 2'b11; step(5);
   endtask

   task automatic t_ctrl_byte();
      ext_int_n = 2'b11;
      do_reset();
      wr_byte(CTRL, 8'h0F); step(3);
      chk("R6 byte flags", req_flag, 2'b11);
      wr_byte(CTRL, 8'h05); step(3);
      chk("R6 byte clear", req_flag, 2'b00);
      ext_int_n = 2'b10; step(5);
      ext_int_n = 2'b11; step(5);
      chk("R6 type bit0 edge", req_flag, 2'b01);
   endtask

   task automatic t_bit();
      ext_int_n = 2'b11;
      do_reset();
      wr_one(CTRL + 8'd2, 1'b1);
      wr_one(CTRL + 8'd3, 1'b1); step(3);
      chk("R7 bit flag1", req_flag, 2'b10);
      ext_int_n = 2'b10; step(5);
      ext_int_n = 2'b11; step(5);
      chk("R7 ch0 still level", req_flag, 2'b10);
      wr_one(ENA + 8'd1, 1'b1); step(3);
      chk("R7 bit enable1", irq_pend, 2'b10);
   endtask

   task automatic t_enable_prio();
      ext_int_n = 2'b11;
      do_reset();
      wr_byte(CTRL, 8'h0F); step(3);
      chk("R8 disabled pend", irq_pend, 2'b00);
      chk("R8 disabled req", irq_req, 1'b0);
      wr_byte(ENA, 8'h01); step(3);
      chk("R8 enable0 pend", irq_pend, 2'b01);
      wr_byte(ENA, 8'h03); step(3);
      chk("R9 both pend", irq_pend, 2'b11);
      chk("R9 ch0 wins", irq_vec, 16'h0003);
      ack(2'b01); step(3);
      chk("R9 ch1 vec", irq_vec, 16'h0013);
      ack(2'b10); step(3);
      chk("R9 none vec", irq_vec, 16'h0000);
      chk("R9 none req", irq_req, 1'b0);
   endtask

   task automatic t_sw();
      ext_int_n = 2'b11;
      do_reset();
      wr_byte(CTRL, 8'h05);
      wr_byte(ENA, 8'h02);
      wr_one(CTRL + 8'd3, 1'b1); step(3);
      chk("R10 sw pend", irq_pend, 2'b10);
      chk("R10 sw vec", irq_vec, 16'h0013);
      ack(2'b10); step(3);
      chk("R10 sw ack clears", req_flag, 2'b00);
      chk("R10 sw req low", irq_req, 1'b0);
   endtask

   initial begin
      t_reset();
      t_level();
      t_edge();
      t_noedge();
      t_ack();
      t_ctrl_byte();
      t_bit();
      t_enable_prio();
      t_sw();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule